// File: doc/BRIEF.md
# IrDA-capable serial character receiver

This block receives asynchronous serial characters and sits on a 16x oversampling tick enable that comes from outside. A mode input picks the line timing. In plain mode the receiver reads a normal idle-high serial line. In infrared mode it reads the output of an on-board pulse decoder. That decoder turns each short high pulse on the infrared input into a full bit period of logic zero. The character format is set by inputs: five to eight data bits, optional even or odd parity, and one or two stop bits. Every completed character goes out on a valid/ready port together with a four-bit status code.

The same block also encodes an outgoing serial bit stream for an infrared emitter. A zero bit becomes a short high pulse at the start of its bit period. A one bit becomes a steady low level. The block has no baud generator, no queueing and no register access. Software or a neighbouring block supplies the tick, the format inputs and the transmit bit stream.

Top module: `sir_uart_rx`

## Requirements
- R1: While reset is held, `out_valid` and `ir_out` are 0.
- R2: In plain mode a falling edge of `rx_line`, seen on a tick, starts a frame. The line is checked for low on the 8th tick after the edge tick, and every later bit is sampled every 16 ticks after that. Data is taken least-significant bit first, and a clean character has status 0.
- R3: If the line is high at the start-check tick, the start is dropped and no character is produced.
- R4: With `irda_en`=1 the start check moves to the 4th tick after the edge, and the receiver reads the decoded infrared line instead of `rx_line`.
- R5: `wlen` selects 5, 6, 7 or 8 data bits (values 0 to 3). Any bit of `out_data` above the word length is 0.
- R6: With `par_en`=1 one parity bit follows the data. `par_odd`=0 means even parity over data plus parity bit, and 1 means odd. A mismatch sets status bit 1.
- R7: Every stop bit (one, or two when `two_stop`=1) must be sampled high. Otherwise status bit 0 (framing) is set.
- R8: If every sampled data, parity and stop bit is low, status bit 2 (break) is set together with bit 0. `out_data` is 0 and the parity flag is cleared.
- R9: If a character completes while `out_valid` is high and `out_ready` is low, the new character is discarded and the held one stays. The next character that is delivered carries status bit 3 (overrun).
- R10: Once `out_valid` is high, it and `out_data`/`out_status` stay unchanged until a cycle with `out_ready` high. A character completing in that same cycle is loaded directly.
- R11: On each tick the encoder restarts its 16-tick phase when `tx_line` changes. `ir_out` is high for the first 3 ticks of the phase while `tx_line` is 0, and low otherwise.
- R12: A tick that samples `ir_in` high drives the decoded line low. The decoded line stays low until 16 ticks have passed with no high sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| irda_en | input | 1 | 1 selects infrared timing and the decoded input |
| wlen | input | 2 | Data bit count minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| two_stop | input | 1 | 1 selects two stop bits |
| rx_line | input | 1 | Plain serial input, idle high |
| ir_in | input | 1 | Infrared receive input, idle low |
| tx_line | input | 1 | Serial bit stream to be encoded, idle high |
| ir_out | output | 1 | Encoded infrared pulse output |
| out_valid | output | 1 | A character is held |
| out_ready | input | 1 | Consumer accepts the held character |
| out_data | output | 8 | Received character, zero-extended |
| out_status | output | 4 | {overrun, break, parity error, framing error} |

## Verification
The bench uses the default parameters: 16 ticks per bit, start checks at ticks 8 and 4, a 3-tick pulse and an 8-bit data path. It issues a tick every fourth clock, so a whole frame takes under a thousand cycles. That leaves room to cover all four word lengths, both parities, two stop bits, break, a false start, overrun and an infrared frame within one run. A behavioural tick-level model of the pulse decoder, the sampling instants and the output slot is checked against the ports on every clock.

// File: rtl/sir_uart_pkg.sv
package sir_uart_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    localparam int ST_FRAME   = 0;
    localparam int ST_PARITY  = 1;
    localparam int ST_BREAK   = 2;
    localparam int ST_OVERRUN = 3;
    localparam int CORE_ST_W  = 3;
    localparam int STATUS_W   = 4;
endpackage

// File: rtl/sir_pulse_enc.sv
module sir_pulse_enc #(
    parameter int OVS   = 16,
    parameter int PULSE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic tx_i,
    output logic ir_o
);
    localparam int CW = $clog2(OVS);

    typedef struct packed {
        logic          last;
        logic [CW-1:0] ph;
        logic          ir;
    } enc_t;

    enc_t enc_d, enc_q;

    always_comb begin
        enc_d = enc_q;
        if (tick_i) begin
            enc_d.last = tx_i;
            if (tx_i != enc_q.last)
                enc_d.ph = '0;
            else if (enc_q.ph == CW'(OVS - 1))
                enc_d.ph = '0;
            else
                enc_d.ph = enc_q.ph + 1'b1;
            enc_d.ir = ~tx_i && (enc_d.ph < CW'(PULSE));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) enc_q <= '{last: 1'b1, ph: '0, ir: 1'b0};
        else        enc_q <= enc_d;
    end

    assign ir_o = enc_q.ir;

    // R11
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ir_o |-> (enc_q.ph < CW'(PULSE)));
endmodule

// File: rtl/sir_pulse_dec.sv
module sir_pulse_dec #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic ir_i,
    output logic line_o
);
    localparam int CW = $clog2(OVS);

    typedef struct packed {
        logic [CW-1:0] hold;
        logic          line;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d = dec_q;
        if (tick_i) begin
            if (ir_i) begin
                dec_d.hold = CW'(OVS - 1);
                dec_d.line = 1'b0;
            end else if (dec_q.hold != '0) begin
                dec_d.hold = dec_q.hold - 1'b1;
                dec_d.line = 1'b0;
            end else begin
                dec_d.line = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '{hold: '0, line: 1'b1};
        else        dec_q <= dec_d;
    end

    assign line_o = dec_q.line;

    // R12
    stretch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && ir_i) |=> !line_o);
endmodule

// File: rtl/sir_rx_core.sv
module sir_rx_core
    import sir_uart_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int DW       = 8,
    parameter int CHK_UART = 8,
    parameter int CHK_IRDA = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 line_i,
    input  logic                 irda_i,
    input  logic [1:0]           wlen_i,
    input  logic                 par_en_i,
    input  logic                 par_odd_i,
    input  logic                 two_stop_i,
    output logic                 done_o,
    output logic [DW-1:0]        char_o,
    output logic [CORE_ST_W-1:0] stat_o
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DW);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] tcnt;
        logic [BW-1:0] bidx;
        logic [DW-1:0] shreg;
        logic          pbit;
        logic          second;
        logic          ferr;
        logic          all_low;
        logic          prev;
    } core_t;

    core_t core_d, core_q;

    logic [CW-1:0] chk_m1;
    logic [BW-1:0] last_idx;
    logic          at_bit;
    logic          ferr_n, low_n, brk;

    assign chk_m1   = irda_i ? CW'(CHK_IRDA - 1) : CW'(CHK_UART - 1);
    assign last_idx = BW'(32'd4 + 32'(wlen_i));
    assign at_bit   = (core_q.tcnt == CW'(OVS - 1));
    assign ferr_n   = core_q.ferr | ~line_i;
    assign low_n    = core_q.all_low & ~line_i;
    assign brk      = low_n;

    always_comb begin
        core_d = core_q;
        done_o = 1'b0;
        char_o = '0;
        stat_o = '0;
        if (tick_i) begin
            core_d.prev = line_i;
            core_d.tcnt = core_q.tcnt + 1'b1;
            unique case (core_q.st)
                RX_IDLE: begin
                    if (core_q.prev && !line_i) begin
                        core_d.st   = RX_START;
                        core_d.tcnt = '0;
                    end
                end
                RX_START: begin
                    if (core_q.tcnt == chk_m1) begin
                        core_d.tcnt = '0;
                        if (line_i) begin
                            core_d.st = RX_IDLE;
                        end else begin
                            core_d.st      = RX_DATA;
                            core_d.bidx    = '0;
                            core_d.shreg   = '0;
                            core_d.pbit    = 1'b0;
                            core_d.second  = 1'b0;
                            core_d.ferr    = 1'b0;
                            core_d.all_low = 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (at_bit) begin
                        core_d.tcnt              = '0;
                        core_d.shreg[core_q.bidx] = line_i;
                        core_d.all_low           = low_n;
                        if (core_q.bidx == last_idx)
                            core_d.st = par_en_i ? RX_PAR : RX_STOP;
                        else
                            core_d.bidx = core_q.bidx + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (at_bit) begin
                        core_d.tcnt    = '0;
                        core_d.pbit    = line_i;
                        core_d.all_low = low_n;
                        core_d.st      = RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (at_bit) begin
                        core_d.tcnt = '0;
                        if (two_stop_i && !core_q.second) begin
                            core_d.second  = 1'b1;
                            core_d.ferr    = ferr_n;
                            core_d.all_low = low_n;
                        end else begin
                            core_d.st          = RX_IDLE;
                            done_o             = 1'b1;
                            char_o             = brk ? '0 : core_q.shreg;
                            stat_o[ST_FRAME]   = ferr_n;
                            stat_o[ST_BREAK]   = brk;
                            stat_o[ST_PARITY]  = par_en_i && !brk &&
                                                 ((^core_q.shreg) ^ core_q.pbit ^ par_odd_i);
                        end
                    end
                end
                default: core_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q      <= '0;
            core_q.st   <= RX_IDLE;
            core_q.prev <= 1'b1;
        end else begin
            core_q <= core_d;
        end
    end

    // R2
    done_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> tick_i);

    // R3
    start_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == RX_START) |-> (core_q.tcnt < CW'(CHK_UART)));

    // R8
    break_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && stat_o[ST_BREAK]) |-> ((char_o == '0) && stat_o[ST_FRAME] && !stat_o[ST_PARITY]));
endmodule

// File: rtl/sir_rx_slot.sv
module sir_rx_slot
    import sir_uart_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done_i,
    input  logic [DW-1:0]        char_i,
    input  logic [CORE_ST_W-1:0] stat_i,
    input  logic                 ready_i,
    output logic                 valid_o,
    output logic [DW-1:0]        data_o,
    output logic [STATUS_W-1:0]  status_o
);
    typedef struct packed {
        logic                valid;
        logic [DW-1:0]       data;
        logic [STATUS_W-1:0] status;
        logic                pend;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  room;

    assign room = !slot_q.valid || ready_i;

    always_comb begin
        slot_d = slot_q;
        if (done_i) begin
            if (room) begin
                slot_d.valid  = 1'b1;
                slot_d.data   = char_i;
                slot_d.status = {slot_q.pend, stat_i};
                slot_d.pend   = 1'b0;
            end else begin
                slot_d.pend = 1'b1;
            end
        end else if (slot_q.valid && ready_i) begin
            slot_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign valid_o  = slot_q.valid;
    assign data_o   = slot_q.data;
    assign status_o = slot_q.status;

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(status_o)));

    // R9
    overrun_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && valid_o && !ready_i) |=> slot_q.pend);
endmodule

// File: rtl/sir_uart_rx.sv
module sir_uart_rx
    import sir_uart_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int DW       = 8,
    parameter int CHK_UART = 8,
    parameter int CHK_IRDA = 4,
    parameter int PULSE    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick16,
    input  logic                irda_en,
    input  logic [1:0]          wlen,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                two_stop,
    input  logic                rx_line,
    input  logic                ir_in,
    input  logic                tx_line,
    output logic                ir_out,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [DW-1:0]       out_data,
    output logic [STATUS_W-1:0] out_status
);
    logic                 dec_line;
    logic                 core_line;
    logic                 done;
    logic [DW-1:0]        chr;
    logic [CORE_ST_W-1:0] cst;

    sir_pulse_enc #(.OVS(OVS), .PULSE(PULSE)) u_enc (
        .clk(clk), .rst_n(rst_n), .tick_i(tick16), .tx_i(tx_line), .ir_o(ir_out)
    );

    sir_pulse_dec #(.OVS(OVS)) u_dec (
        .clk(clk), .rst_n(rst_n), .tick_i(tick16), .ir_i(ir_in), .line_o(dec_line)
    );

    assign core_line = irda_en ? dec_line : rx_line;

    sir_rx_core #(.OVS(OVS), .DW(DW), .CHK_UART(CHK_UART), .CHK_IRDA(CHK_IRDA)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick16), .line_i(core_line),
        .irda_i(irda_en), .wlen_i(wlen), .par_en_i(par_en), .par_odd_i(par_odd),
        .two_stop_i(two_stop), .done_o(done), .char_o(chr), .stat_o(cst)
    );

    sir_rx_slot #(.DW(DW)) u_slot (
        .clk(clk), .rst_n(rst_n), .done_i(done), .char_i(chr), .stat_i(cst),
        .ready_i(out_ready), .valid_o(out_valid), .data_o(out_data), .status_o(out_status)
    );
endmodule

// File: tb/test_sir_uart_rx.sv
module test_sir_uart_rx;
    logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0;
    logic irda_en = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
    logic [1:0] wlen = 2'd3;
    logic rx_line = 1'b1, ir_in = 1'b0, tx_line = 1'b1, out_ready = 1'b0;
    logic ir_out, out_valid;
    logic [7:0] out_data;
    logic [3:0] out_status;

    int compared = 0, mismatched = 0;
    bit finished = 1'b0;
    int tdiv = 0;

    sir_uart_rx i_sir_uart_rx (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .irda_en(irda_en), .wlen(wlen),
        .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop), .rx_line(rx_line),
        .ir_in(ir_in), .tx_line(tx_line), .ir_out(ir_out), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_status(out_status)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tdiv   = (tdiv + 1) % 4;
        tick16 = (tdiv == 0);
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit   m_busy, m_prev, m_dec, m_last, m_pend;
    int   m_k, m_tsh, m_ph;
    bit   m_samp[$];
    logic m_valid, m_ir;
    logic [7:0] m_data;
    logic [3:0] m_stat;

    always @(posedge clk) begin
        bit free, fin, lin, allz, fr, pe;
        int nb, need, chk;
        logic [7:0] cd;
        if (!rst_n) begin
            m_busy = 0; m_prev = 1; m_tsh = 16; m_dec = 1; m_last = 1; m_ph = 0;
            m_ir = 0; m_valid = 0; m_pend = 0; m_data = '0; m_stat = '0; m_k = 0;
        end else begin
            free = !m_valid || out_ready;
            fin  = 0;
            cd   = '0;
            allz = 0; fr = 0; pe = 0;
            if (tick16) begin
                lin  = irda_en ? m_dec : rx_line;
                nb   = 5 + int'(wlen);
                need = nb + int'(par_en) + 1 + int'(two_stop);
                chk  = irda_en ? 4 : 8;
                if (!m_busy) begin
                    if (m_prev && !lin) begin m_busy = 1; m_k = 0; m_samp.delete(); end
                end else begin
                    m_k++;
                    if (m_k == chk) begin
                        if (lin) m_busy = 0;
                    end else if (m_k > chk && (m_k - chk) % 16 == 0) begin
                        m_samp.push_back(lin);
                        if (m_samp.size() == need) begin
                            for (int i = 0; i < nb; i++) cd[i] = m_samp[i];
                            allz = 1;
                            foreach (m_samp[i]) if (m_samp[i]) allz = 0;
                            for (int i = nb + int'(par_en); i < need; i++) if (!m_samp[i]) fr = 1;
                            pe = par_en && ((^cd) ^ m_samp[nb] ^ par_odd);
                            if (allz) pe = 0;
                            fin = 1;
                            m_busy = 0;
                        end
                    end
                end
                m_prev = lin;
                if (ir_in) m_tsh = 0; else if (m_tsh < 16) m_tsh++;
                m_dec = (m_tsh >= 16);
                if (tx_line != m_last) m_ph = 0; else m_ph = (m_ph + 1) % 16;
                m_last = tx_line;
                m_ir = !tx_line && (m_ph < 3);
            end
            if (fin) begin
                if (free) begin
                    m_valid = 1; m_data = cd;
                    m_stat = {m_pend, allz, pe, fr};
                    m_pend = 0;
                end else m_pend = 1;
            end else if (m_valid && out_ready) m_valid = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R10 out_valid vs model", out_valid, m_valid);
            if (m_valid) begin
                check("R10 out_data vs model", out_data, m_data);
                check("R10 out_status vs model", out_status, m_stat);
            end
            check("R11 ir_out vs model", ir_out, m_ir);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_ticks(input int n);
        int c = 0;
        while (c < n) begin
            @(posedge clk);
            if (tick16) c++;
        end
        @(negedge clk);
    endtask

    task automatic drive_seq(input logic [15:0] seq, input int n);
        for (int i = 0; i < n; i++) begin
            if (irda_en) begin
                if (!seq[i]) begin
                    ir_in = 1'b1; wait_ticks(3); ir_in = 1'b0; wait_ticks(13);
                end else wait_ticks(16);
            end else begin
                rx_line = seq[i];
                wait_ticks(16);
            end
        end
        rx_line = 1'b1; ir_in = 1'b0;
        wait_ticks(24);
    endtask

    task automatic send(input logic [7:0] data, input bit bad_par, input logic [1:0] bad_stop);
        logic [15:0] seq = '0;
        int n = 1;
        int nb = 5 + int'(wlen);
        for (int i = 0; i < nb; i++) begin seq[n] = data[i]; n++; end
        if (par_en) begin seq[n] = (^data) ^ par_odd ^ bad_par; n++; end
        seq[n] = !bad_stop[0]; n++;
        if (two_stop) begin seq[n] = !bad_stop[1]; n++; end
        drive_seq(seq, n);
    endtask

    task automatic take(input string tag, input logic [7:0] ed, input logic [3:0] es);
        check({tag, " valid"}, out_valid, 1);
        check({tag, " data"}, out_data, ed);
        check({tag, " status"}, out_status, es);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1'b1;
            mismatched++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        int hi;
        repeat (5) @(negedge clk);
        check("R1 reset out_valid", out_valid, 0);
        check("R1 reset ir_out", ir_out, 0);
        rst_n = 1'b1;
        wait_ticks(20);

        // R2: plain 8N1
        send(8'hA5, 0, 2'b00);
        take("R2 8N1 A5", 8'hA5, 4'h0);

        // R5: word lengths
        wlen = 2'd0; send(8'h15, 0, 2'b00); take("R5 5-bit", 8'h15, 4'h0);
        wlen = 2'd1; send(8'h2B, 0, 2'b00); take("R5 6-bit", 8'h2B, 4'h0);
        wlen = 2'd2; send(8'h5A, 0, 2'b00); take("R5 7-bit", 8'h5A, 4'h0);
        wlen = 2'd3;

        // R3: false start, then normal reception resumes
        rx_line = 1'b0; wait_ticks(4); rx_line = 1'b1; wait_ticks(40);
        check("R3 false start no char", out_valid, 0);
        send(8'h3E, 0, 2'b00); take("R3 after false start", 8'h3E, 4'h0);

        // R6: parity
        par_en = 1'b1;
        send(8'h07, 0, 2'b00); take("R6 even good", 8'h07, 4'h0);
        send(8'h07, 1, 2'b00); take("R6 even bad", 8'h07, 4'h2);
        par_odd = 1'b1;
        send(8'hC3, 0, 2'b00); take("R6 odd good", 8'hC3, 4'h0);
        send(8'hC3, 1, 2'b00); take("R6 odd bad", 8'hC3, 4'h2);
        par_en = 1'b0; par_odd = 1'b0;

        // R7: framing, one and two stop bits
        send(8'h81, 0, 2'b01); take("R7 stop low", 8'h81, 4'h1);
        two_stop = 1'b1;
        send(8'h42, 0, 2'b00); take("R7 two stops ok", 8'h42, 4'h0);
        send(8'h42, 0, 2'b10); take("R7 second stop low", 8'h42, 4'h1);

        // R8: break with odd parity and two stops
        par_en = 1'b1; par_odd = 1'b1;
        drive_seq(16'h0000, 12);
        take("R8 break", 8'h00, 4'h5);
        par_en = 1'b0; par_odd = 1'b0; two_stop = 1'b0;

        // R9: overrun
        send(8'h11, 0, 2'b00);
        send(8'h22, 0, 2'b00);
        check("R9 held char kept", out_data, 8'h11);
        check("R9 held status kept", out_status, 4'h0);
        take("R9 first char", 8'h11, 4'h0);
        send(8'h33, 0, 2'b00);
        take("R9 overrun flagged", 8'h33, 4'h8);

        // R4 and R12: infrared reception
        irda_en = 1'b1;
        wait_ticks(20);
        send(8'h3C, 0, 2'b00); take("R4 R12 irda 3C", 8'h3C, 4'h0);
        send(8'h00, 0, 2'b00); take("R12 irda zeros", 8'h00, 4'h0);
        par_en = 1'b1;
        send(8'hF1, 0, 2'b00); take("R4 irda parity", 8'hF1, 4'h0);
        par_en = 1'b0;
        irda_en = 1'b0;
        wait_ticks(20);

        // R11: encoder pulse widths
        tx_line = 1'b0;
        hi = 0;
        for (int i = 0; i < 32; i++) begin wait_ticks(1); if (ir_out) hi++; end
        check("R11 two zero bits pulse ticks", hi, 6);
        tx_line = 1'b1;
        hi = 0;
        for (int i = 0; i < 16; i++) begin wait_ticks(1); if (ir_out) hi++; end
        check("R11 one bit no pulse", hi, 0);

        wait_ticks(4);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule